// File: doc/BRIEF.md
# Programmable Sinc3 Decimation Filter

This block turns a one-bit sigma-delta modulator stream into signed 24-bit conversion results. Each modulator bit is taken only in a clock cycle where its sample enable is high, and a bit of 1 counts as +1 and a bit of 0 as -1. A third-order integrator and comb core decimates the stream by a ratio chosen from a 7-bit rate code. Two codes of that field select fixed ratios for 60 Hz and 50 Hz output with a 512 kHz sample enable.

A 16-bit control word selects the mode. Chop mode alternates the modulator polarity through a phase output, inverts the results taken in the inverted phase and averages pairs. A running average by two can also be enabled on its own. A nonzero averaging factor sums several sinc3 outputs into each conversion. Each write to the control word restarts the filter. A settled flag reports when the results are free of start-up history.

Top module: `sinc3_decim`

## Requirements
- R1: After reset, the result, the valid strobe, the settled flag and the phase output are all 0, and the filter behaves as if the control word were 0x0007.
- R2: Control word fields: [6:0] rate code, [7] ignored, [13:8] averaging factor AF, [14] running-average enable, [15] chop enable.
- R3: For rate codes 0 to 125 the decimation ratio N is (code+1)*64 enabled samples. In plain mode (chop off, AF = 0) one result is produced every N samples. With a constant input its settled value is floor(±N^3 / 2^18): + for a stream of 1s and - for a stream of 0s.
- R4: Rate code 126 gives N = 8533 and rate code 127 gives N = 10240.
- R5: A control write restarts the filter. In the following cycle, settled, the valid strobe and the phase output are 0, and the result timing is counted again from the write.
- R6: In plain mode, settled rises with the 3rd result, or with the 4th if the running average is on. The running average leaves the output interval at N.
- R7: In chop mode with AF = 0, one result is produced every 3N samples. The phase output starts at 0 and toggles after each conversion. A conversion taken in phase 1 is negated, consecutive conversions are averaged, and settled rises with the 2nd result.
- R8: With AF > 0, each conversion spans (AF+3)*N samples and its value is the sum of AF+1 sinc3 outputs. Turning chop on leaves this interval unchanged. Settled rises with the 1st result, or with the 2nd when chop or the running average is on.
- R9: The valid strobe lasts one clock per result. Values are clamped to ±8388607.
- R10: Cycles with the sample enable low change nothing, whatever the modulator bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Control word write strobe |
| cfgData | input | 16 | Control word value |
| sampleEn | input | 1 | Modulator sample enable |
| modBit | input | 1 | Modulator output bit |
| result | output | 24 | Signed conversion result |
| resultValid | output | 1 | One-cycle strobe per result |
| settled | output | 1 | Results free of start-up history |
| chopPhase | output | 1 | Polarity of the current chop phase |

## Verification
The assertions assume that every conversion spans at least 64 enabled samples, so valid pulses can never be adjacent. They also assume that a control write may come in any cycle and overrides a sample in that same cycle. The stimulus keeps within these assumptions: it changes inputs only on the falling edge, holds the sample enable low while it writes, and in chop mode inverts the modulator level according to the phase output, as the analog front end would. It also runs one section with the enable high only every other cycle and random bits in the idle cycles, to show that only enabled samples count.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int ORDER      = 3;
  localparam int CODE_W     = 7;
  localparam int AF_W       = 6;
  localparam int RATIO_W    = 14;
  localparam int BASE_SHIFT = 6;
  localparam logic [RATIO_W-1:0] RATIO_60HZ = 14'd8533;
  localparam logic [RATIO_W-1:0] RATIO_50HZ = 14'd10240;

  typedef struct packed {
    logic              chopOn;
    logic              avgOn;
    logic [AF_W-1:0]   avgFactor;
    logic              shapeMod;
    logic [CODE_W-1:0] rateCode;
  } filtCfg_t;

  typedef struct packed {
    logic flush;
    logic advance;
    logic coreClr;
    logic decim;
    logic sumLoad;
    logic sumAdd;
    logic finish;
    logic negate;
    logic pairAvg;
  } pathCtl_t;

  function automatic logic [RATIO_W-1:0] ratioOf(input logic [CODE_W-1:0] code);
    if (code == 7'd126) return RATIO_60HZ;
    if (code == 7'd127) return RATIO_50HZ;
    return (RATIO_W'(code) + RATIO_W'(1)) << BASE_SHIFT;
  endfunction
endpackage

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
  import sinc3_pkg::*;
#(
  parameter logic [15:0] CFG_RESET = 16'h0007
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [15:0] cfgData,
  input  logic        sampleEn,
  output pathCtl_t    ctl,
  output logic        chopPhase,
  output logic        settled
);
  localparam int DEC_W = AF_W + 1;

  filtCfg_t           cfgReg;
  logic [RATIO_W-1:0] ratio, sampleCnt;
  logic [DEC_W-1:0]   decCnt;
  logic [2:0]         resCnt, needed;
  logic               restart, pairOn, lastSample, convEnd;
  logic               pLoad, pAdd, pFin, pNeg;

  assign ratio      = ratioOf(cfgReg.rateCode);
  assign restart    = cfgReg.chopOn | (cfgReg.avgFactor != '0);
  assign pairOn     = cfgReg.chopOn | cfgReg.avgOn;
  assign lastSample = sampleEn && !cfgWe && (sampleCnt == ratio - RATIO_W'(1));
  assign convEnd    = lastSample &&
                      (!restart || decCnt == DEC_W'(cfgReg.avgFactor) + DEC_W'(2));
  assign needed     = restart ? (pairOn ? 3'd2 : 3'd1) : (3'(ORDER) + 3'(pairOn));

  always_comb begin
    ctl.flush   = cfgWe;
    ctl.advance = sampleEn && !cfgWe;
    ctl.coreClr = cfgWe || (restart && convEnd);
    ctl.decim   = lastSample;
    ctl.sumLoad = pLoad;
    ctl.sumAdd  = pAdd;
    ctl.finish  = pFin;
    ctl.negate  = pNeg;
    ctl.pairAvg = pairOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg    <= filtCfg_t'(CFG_RESET);
      sampleCnt <= '0;
      decCnt    <= '0;
      resCnt    <= '0;
      settled   <= 1'b0;
      chopPhase <= 1'b0;
      {pLoad, pAdd, pFin, pNeg} <= '0;
    end else if (cfgWe) begin
      cfgReg    <= filtCfg_t'(cfgData);
      sampleCnt <= '0;
      decCnt    <= '0;
      resCnt    <= '0;
      settled   <= 1'b0;
      chopPhase <= 1'b0;
      {pLoad, pAdd, pFin, pNeg} <= '0;
    end else begin
      pLoad <= lastSample && (!restart || decCnt == DEC_W'(2));
      pAdd  <= lastSample && restart && (decCnt > DEC_W'(2));
      pFin  <= convEnd;
      pNeg  <= convEnd && cfgReg.chopOn && chopPhase;
      if (sampleEn) sampleCnt <= lastSample ? '0 : sampleCnt + RATIO_W'(1);
      if (lastSample) decCnt <= convEnd ? '0 : decCnt + DEC_W'(1);
      if (convEnd && cfgReg.chopOn) chopPhase <= ~chopPhase;
      if (pFin) begin
        if (resCnt < needed) resCnt <= resCnt + 3'd1;
        if (resCnt + 3'd1 >= needed) settled <= 1'b1;
      end
    end
  end

  // R5: a write clears settled and phase in the next cycle
  p_write_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (!settled && !chopPhase));
  // R6: settled holds until the next write
  p_settled_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (settled && !cfgWe) |=> settled);
  // R7: the phase stays at 0 while chop is off
  p_phase_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !cfgReg.chopOn |-> !chopPhase);
  // R10: the sample counter stays frozen while the enable is low
  p_count_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleEn && !cfgWe) |=> $stable(sampleCnt));
  // R3: the counter stays within the current ratio
  p_count_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    sampleCnt < ratio);
endmodule

// File: rtl/sinc3_path.sv
module sinc3_path
  import sinc3_pkg::*;
#(
  parameter int ACC_W = 42,
  parameter int OUT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  pathCtl_t         ctl,
  input  logic             modBit,
  output logic [OUT_W-1:0] result,
  output logic             resultValid
);
  localparam int SUM_W = ACC_W + AF_W + 1;
  localparam int SHIFT = ACC_W - OUT_W;
  localparam int V_W   = OUT_W + 1;
  localparam int P_W   = OUT_W + 2;
  localparam logic signed [ACC_W-1:0] ONE = ACC_W'(1);
  localparam logic signed [SUM_W-1:0] HI  = {{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] LO  = -HI;

  logic signed [ACC_W-1:0] integ [ORDER];
  logic signed [ACC_W-1:0] intNext [ORDER];
  logic signed [ACC_W-1:0] dly [ORDER];
  logic signed [ACC_W-1:0] dlyIn [ORDER];
  logic signed [ACC_W-1:0] combOut [ORDER];
  logic signed [ACC_W-1:0] xIn, decOut;
  logic signed [SUM_W-1:0] acc, decExt, sumNext, scaled;
  logic signed [V_W-1:0]   clipped, signedVal, prevVal;
  logic signed [P_W-1:0]   pairSum;
  logic [OUT_W-1:0]        outWord;

  assign xIn = modBit ? ONE : -ONE;

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign intNext[k] = integ[k] + xIn;
      assign dlyIn[k]   = intNext[ORDER-1];
    end else begin : g_rest
      assign intNext[k] = integ[k] + intNext[k-1];
      assign dlyIn[k]   = combOut[k-1];
    end
    assign combOut[k] = dlyIn[k] - dly[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    for (int k = 0; k < ORDER; k++) begin
      if (!rstN || ctl.coreClr) begin
        integ[k] <= '0;
        dly[k]   <= '0;
      end else begin
        if (ctl.advance) integ[k] <= intNext[k];
        if (ctl.decim) dly[k] <= dlyIn[k];
      end
    end
  end

  assign decExt    = SUM_W'(decOut);
  assign sumNext   = ctl.sumLoad ? decExt : acc + decExt;
  assign scaled    = sumNext >>> SHIFT;

  always_comb begin
    if (scaled > HI)      clipped = V_W'(HI);
    else if (scaled < LO) clipped = V_W'(LO);
    else                  clipped = V_W'(scaled);
  end

  assign signedVal = ctl.negate ? -clipped : clipped;
  assign pairSum   = P_W'(signedVal) + P_W'(prevVal);
  assign outWord   = ctl.pairAvg ? pairSum[OUT_W:1] : signedVal[OUT_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decOut      <= '0;
      acc         <= '0;
      prevVal     <= '0;
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      if (ctl.flush) begin
        acc     <= '0;
        prevVal <= '0;
      end else begin
        if (ctl.decim) decOut <= combOut[ORDER-1];
        if (ctl.sumLoad || ctl.sumAdd) acc <= sumNext;
        if (ctl.finish) begin
          result      <= outWord;
          resultValid <= 1'b1;
          prevVal     <= signedVal;
        end
      end
    end
  end

  // R9: the valid strobe is a single-cycle pulse
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);
  // R9: the clamp is symmetric, so the most negative code never appears
  p_clip_symmetric_r9: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (result != {1'b1, {(OUT_W-1){1'b0}}}));
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
  import sinc3_pkg::*;
#(
  parameter int          ACC_W     = 42,
  parameter int          OUT_W     = 24,
  parameter logic [15:0] CFG_RESET = 16'h0007
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [15:0]      cfgData,
  input  logic             sampleEn,
  input  logic             modBit,
  output logic [OUT_W-1:0] result,
  output logic             resultValid,
  output logic             settled,
  output logic             chopPhase
);
  pathCtl_t ctl;

  sinc3_ctrl #(.CFG_RESET(CFG_RESET)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgData   (cfgData),
    .sampleEn  (sampleEn),
    .ctl       (ctl),
    .chopPhase (chopPhase),
    .settled   (settled)
  );

  sinc3_path #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .modBit      (modBit),
    .result      (result),
    .resultValid (resultValid)
  );
endmodule

// File: tb/sinc3_decim_test.sv
module sinc3_decim_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [15:0] cfgData = 16'h0;
  logic        sampleEn = 1'b0;
  logic        modBit = 1'b0;
  logic [23:0] result;
  logic        resultValid, settled, chopPhase;

  sinc3_decim uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .sampleEn(sampleEn), .modBit(modBit), .result(result),
    .resultValid(resultValid), .settled(settled), .chopPhase(chopPhase)
  );

  always #2 clk = ~clk;

  typedef struct {
    bit     chkVal;
    longint val;
    bit     st;
    int     ph;
    longint at;
    string  tag;
  } exp_t;

  exp_t   q[$];
  int     checks = 0;
  int     failures = 0;
  longint sampCnt = 0;
  longint cyc = 0;
  bit     hold = 1'b1;
  bit     sparse = 1'b0;
  bit     chopInv = 1'b0;
  bit     level = 1'b1;
  bit     toggle = 1'b0;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint dcVal(longint n, bit lvl, longint mult);
    longint v;
    v = n * n * n * mult;
    if (!lvl) v = -v;
    v = v >>> 18;
    if (v > 8388607) v = 8388607;
    if (v < -8388607) v = -8388607;
    return v;
  endfunction

  task automatic expectRes(bit chk, longint val, bit st, int ph, longint at, string tag);
    exp_t e;
    e.chkVal = chk; e.val = val; e.st = st; e.ph = ph; e.at = at; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic waitDone();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic runCfg(logic [15:0] w);
    @(posedge clk);
    hold = 1'b1;
    @(negedge clk);
    cfgData = w;
    cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
    sampCnt = 0;
    hold = 1'b0;
    check("R5 settled after write", settled, 0);
    check("R5 valid after write", resultValid, 0);
    check("R5 phase after write", chopPhase, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (sampleEn === 1'b1) sampCnt++;
  end

  always @(negedge clk) begin
    if (hold) sampleEn = 1'b0;
    else if (sparse) begin
      toggle = ~toggle;
      sampleEn = toggle;
    end else sampleEn = 1'b1;
    modBit = sampleEn ? (level ^ (chopInv & chopPhase)) : 1'($urandom);
  end

  initial begin
    exp_t   e;
    longint d;
    forever begin
      @(negedge clk);
      if (resultValid === 1'b1 && q.size() > 0) begin
        e = q.pop_front();
        if (e.chkVal) check({e.tag, " value"}, longint'(signed'(result)), e.val);
        check({e.tag, " settled"}, settled, e.st);
        if (e.ph >= 0) check({e.tag, " phase"}, chopPhase, e.ph);
        d = sampCnt - e.at;
        check({e.tag, " timing"}, (d >= 0 && d <= 2) ? 1 : 0, 1);
        @(negedge clk);
        check({e.tag, " R9 pulse"}, resultValid, 0);
      end
    end
  end

  initial begin
    wait (cyc >= 180000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", q.size());
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset result", result, 0);
    check("R1 reset valid", resultValid, 0);
    check("R1 reset settled", settled, 0);
    check("R1 reset phase", chopPhase, 0);
    rstN = 1'b1;
    @(negedge clk);
    sampCnt = 0;
    hold = 1'b0;

    // R1 R3 R6: default word, ratio 512, plain mode
    level = 1'b1;
    expectRes(0, 0, 0, 0, 512, "R1 first");
    expectRes(0, 0, 0, 0, 1024, "R1 second");
    expectRes(1, 512, 1, 0, 1536, "R1 R3 R6 third");
    expectRes(1, 512, 1, 0, 2048, "R3 fourth");
    waitDone();

    // R2 R3 R10: bit 7 set, ratio 256, zeros, sparse enable with noise
    runCfg(16'h0083);
    level = 1'b0;
    sparse = 1'b1;
    expectRes(0, 0, 0, 0, 256, "R10 first");
    expectRes(0, 0, 0, 0, 512, "R10 second");
    expectRes(1, -64, 1, 0, 768, "R2 R3 R10 third");
    expectRes(1, -64, 1, 0, 1024, "R10 fourth");
    waitDone();
    sparse = 1'b0;

    // R6: running average without chop, ratio 128
    runCfg(16'h4001);
    level = 1'b1;
    expectRes(0, 0, 0, 0, 128, "R6 ra first");
    expectRes(0, 0, 0, 0, 256, "R6 ra second");
    expectRes(0, 0, 0, 0, 384, "R6 ra third");
    expectRes(1, 8, 1, 0, 512, "R6 ra fourth");
    waitDone();

    // R4: code 126
    runCfg(16'h007E);
    expectRes(0, 0, 0, 0, 8533, "R4 60 first");
    expectRes(0, 0, 0, 0, 17066, "R4 60 second");
    expectRes(1, dcVal(8533, 1, 1), 1, 0, 25599, "R4 60 third");
    waitDone();

    // R4: code 127, zeros
    runCfg(16'h007F);
    level = 1'b0;
    expectRes(0, 0, 0, 0, 10240, "R4 50 first");
    expectRes(0, 0, 0, 0, 20480, "R4 50 second");
    expectRes(1, dcVal(10240, 0, 1), 1, 0, 30720, "R4 50 third");
    waitDone();

    // R7: chop, AF=0, ratio 256, front end inverts by phase
    runCfg(16'h8003);
    level = 1'b1;
    chopInv = 1'b1;
    expectRes(0, 0, 0, 1, 768, "R7 first");
    expectRes(1, 64, 1, 0, 1536, "R7 second");
    expectRes(1, 64, 1, 1, 2304, "R7 third");
    waitDone();

    // R8: AF=2 without chop
    runCfg(16'h0203);
    chopInv = 1'b0;
    expectRes(1, 192, 1, 0, 1280, "R8 af first");
    expectRes(1, 192, 1, 0, 2560, "R8 af second");
    waitDone();

    // R8: AF=2 with chop, same interval
    runCfg(16'h8203);
    chopInv = 1'b1;
    expectRes(0, 0, 0, 1, 1280, "R8 chop first");
    expectRes(1, 192, 1, 0, 2560, "R8 chop second");
    waitDone();

    // R9: clamp with AF=3 at ratio 10240
    runCfg(16'h037F);
    chopInv = 1'b0;
    expectRes(1, 8388607, 1, 0, 61440, "R9 clip");
    waitDone();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule